// File: doc/BRIEF.md
# Chained Multi-Word Right Shifter

This block shifts an unsigned integer of many 64-bit words right by 0 to 63 bit positions, handling one word per accepted step. A run is opened with a start pulse that supplies the word count, the shift amount and a seed for the spill register. Words are then presented from the most significant down to the least significant. Each step produces one shifted result word. It also leaves behind the bits that fall off the bottom of the word, already placed where the next lower word needs them.

Each step rotates the incoming word right by the shift amount. A mask with ones in the low 64-n positions then splits the rotated word into two parts. The masked part forms the body of the result word. The top n positions of the result are filled from the spill held over from the word above. The unmasked remainder becomes the new spill. After the last word, the spill holds the bits shifted out of the integer, aligned at the top of a word.

Top module: `dword_rshift_chain`

## Requirements
- R1: After reset, busy, res_valid and done are low and spill_out is zero.
- R2: With a start pulse while idle, the unit latches shamt and sets spill_out to spill_in ANDed with a mask that keeps only the top shamt bit positions. Only those top shamt bits of spill_in ever reach a result.
- R3: Each accepted word w produces, one clock later, res_word equal to (w >> n) with its top n bits taken from the top n bits of the held spill.
- R4: After each accepted word, spill_out equals w << (64-n), which is the low n bits of w moved to the top. With n = 0 it is zero.
- R5: For a run of count words given from index count-1 down to 0, the result words equal the whole integer shifted right by n. Each result word carries its own index on res_index.
- R6: When shamt is 0, each result word equals its input word and the top word gets nothing from spill_in.
- R7: done is high for exactly the cycle that carries the result for index 0. busy is low in that cycle, and spill_out holds the final spill until the next start.
- R8: A start with elem_count = 0 gives done one cycle later with no result word, and spill_out is the masked spill_in.
- R9: word_valid while idle produces no result and leaves spill_out unchanged. start while busy is ignored.
- R10: If word_valid is low during a run, the step stalls: no result is produced and the run resumes with the next valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a run when idle |
| elem_count | input | CW | Number of words in the run |
| shamt | input | log2(W) | Right shift amount 0..W-1 |
| spill_in | input | W | Seed spill for the top word (zero for a logical shift) |
| word_valid | input | 1 | word_in carries the next word, most significant first |
| word_in | input | W | Input word |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | res_word and res_index are valid |
| res_word | output | W | Shifted result word |
| res_index | output | CW | Index of the result word |
| done | output | 1 | Last result of the run, or completion of an empty run |
| spill_out | output | W | Current spill, and the bits shifted out once the run ends |

## Verification
The assertions check the following on every cycle:
- done coincides with the index-0 result and with busy low.
- Results only appear after a busy cycle.
- The spill stays frozen while idle without a start.
- A zero shift leaves a zero spill.

Only the bench scenarios can show that the word values are arithmetically right. The bench sweeps every shift amount over several run lengths and compares each result and the final spill with a wide shift of the concatenated words. It also covers masking of the spill seed, stalls, a start given mid-run, and an empty run.

// File: rtl/dword_rshift_chain.sv
module dword_rshift_chain #(
  parameter int W  = 64,
  parameter int CW = 8,
  localparam int NW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] elem_count,
  input  logic [NW-1:0] shamt,
  input  logic [W-1:0]  spill_in,
  input  logic          word_valid,
  input  logic [W-1:0]  word_in,
  output logic          busy,
  output logic          res_valid,
  output logic [W-1:0]  res_word,
  output logic [CW-1:0] res_index,
  output logic          done,
  output logic [W-1:0]  spill_out
);

  logic [NW-1:0] n;
  logic [CW-1:0] remain;
  logic [W-1:0]  spill;

  wire [W-1:0] ones   = {W{1'b1}};
  wire [W-1:0] rot    = (word_in >> n) | (word_in << (W - int'(n)));
  wire [W-1:0] mask   = ones >> n;
  wire [W-1:0] t_next = (rot & mask) | (spill & ~mask);
  wire [W-1:0] s_next = rot & ~mask;
  wire [W-1:0] smask  = ones >> shamt;

  assign spill_out = spill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_word  <= '0;
      res_index <= '0;
      done      <= 1'b0;
      n         <= '0;
      remain    <= '0;
      spill     <= '0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          n     <= shamt;
          spill <= spill_in & ~smask;
          if (elem_count == '0) begin
            done <= 1'b1;
          end else begin
            busy   <= 1'b1;
            remain <= elem_count;
          end
        end
      end else if (word_valid) begin
        res_word  <= t_next;
        res_index <= remain - 1'b1;
        res_valid <= 1'b1;
        spill     <= s_next;
        remain    <= remain - 1'b1;
        if (remain == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dword_rshift_chain_chk.sv
module dword_rshift_chain_chk #(
  parameter int W  = 64,
  parameter int CW = 8,
  localparam int NW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          res_valid,
  input logic [CW-1:0] res_index,
  input logic          done,
  input logic [W-1:0]  spill_out,
  input logic [NW-1:0] n
);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (done == (res_index == '0)));

  assert_result_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));

  assert_spill_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(spill_out));

  assert_zero_shift_spill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && n == '0) |-> spill_out == '0);

endmodule

bind dword_rshift_chain dword_rshift_chain_chk #(.W(W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .res_valid(res_valid),
  .res_index(res_index), .done(done), .spill_out(spill_out), .n(n)
);

// File: tb/dword_rshift_chain_tb_top.sv
module dword_rshift_chain_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] elem_count = '0;
  logic [5:0] shamt = '0;
  logic [63:0] spill_in = '0;
  logic word_valid = 1'b0;
  logic [63:0] word_in = '0;
  logic busy, res_valid, done;
  logic [63:0] res_word, spill_out;
  logic [7:0] res_index;

  int tests = 0;
  int fails = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;
  logic [63:0] w [0:3];

  always #10 clk = ~clk;

  dword_rshift_chain #(.W(64), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
    .shamt(shamt), .spill_in(spill_in), .word_valid(word_valid),
    .word_in(word_in), .busy(busy), .res_valid(res_valid),
    .res_word(res_word), .res_index(res_index), .done(done),
    .spill_out(spill_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nextw();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic run(input int cnt, input int sh, input logic [63:0] sp, input bit stall, input bit midstart);
    logic [383:0] big;
    logic [383:0] shv;
    logic [63:0] topbits;
    logic [63:0] expw;
    big = '0;
    for (int i = 0; i < cnt; i++) begin
      w[i] = nextw();
      big[64*(i+1) +: 64] = w[i];
    end
    shv = big >> sh;
    topbits = sp & ~(64'hFFFF_FFFF_FFFF_FFFF >> sh);
    @(negedge clk);
    start = 1'b1; elem_count = 8'(cnt); shamt = 6'(sh); spill_in = sp;
    @(negedge clk);
    start = 1'b0;
    chk(spill_out == topbits, "R2 seed spill", spill_out, topbits);
    if (cnt == 0) begin
      chk(done == 1'b1 && res_valid == 1'b0 && busy == 1'b0, "R8 empty run", {62'b0, done, res_valid}, 64'h2);
      @(negedge clk);
      return;
    end
    chk(busy == 1'b1, "R2 busy after start", {63'b0, busy}, 64'h1);
    for (int k = cnt - 1; k >= 0; k--) begin
      if (stall && k == 0) begin
        word_valid = 1'b0;
        @(posedge clk); #1;
        chk(res_valid == 1'b0 && busy == 1'b1, "R10 stall", {62'b0, res_valid, busy}, 64'h1);
        @(negedge clk);
      end
      word_valid = 1'b1; word_in = w[k];
      if (midstart && k == 1) begin
        start = 1'b1; elem_count = 8'd0; shamt = 6'(sh + 5); spill_in = ~sp;
      end
      @(posedge clk); #1;
      start = 1'b0;
      expw = shv[64*(k+1) +: 64] | ((k == cnt - 1) ? topbits : 64'h0);
      chk(res_valid == 1'b1, "R5 result valid", {63'b0, res_valid}, 64'h1);
      chk(res_word == expw, (sh == 0) ? "R6 zero shift word" : "R3 result word", res_word, expw);
      chk(res_index == 8'(k), "R5 index", {56'b0, res_index}, 64'(k));
      chk(done == (k == 0), "R7 done timing", {63'b0, done}, 64'(k == 0));
      if (k == 0) begin
        chk(spill_out == shv[63:0], "R4 final spill", spill_out, shv[63:0]);
        chk(busy == 1'b0, "R7 idle after last", {63'b0, busy}, 64'h0);
      end
      @(negedge clk);
    end
    word_valid = 1'b1; word_in = nextw();
    @(posedge clk); #1;
    chk(res_valid == 1'b0 && spill_out == shv[63:0], "R9 idle word ignored", spill_out, shv[63:0]);
    @(negedge clk);
    word_valid = 1'b0;
    chk(spill_out == shv[63:0] && done == 1'b0, "R7 spill held", spill_out, shv[63:0]);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && res_valid == 1'b0 && done == 1'b0, "R1 reset flags", {61'b0, busy, res_valid, done}, 64'h0);
    chk(spill_out == 64'h0, "R1 reset spill", spill_out, 64'h0);
    rst_n = 1'b1;
    for (int sh = 0; sh < 64; sh++) begin
      for (int cnt = 1; cnt <= 4; cnt++) begin
        run(cnt, sh, 64'h0, 1'b0, 1'b0);
      end
    end
    for (int sh = 0; sh < 64; sh += 3) begin
      run(3, sh, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
      run(2, sh, nextw(), 1'b1, 1'b0);
      run(4, sh, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 1'b1);
      run(0, sh, nextw(), 1'b0, 1'b0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule